// File: doc/BRIEF.md
# Flash Command Sequencer

This block runs read, program and erase commands against a small on-chip word array that models a flash device. Software drives it through a simple register port. It loads a word address, then writes a control word that carries the command code, the erase scope, the partition, the transfer length and a start bit. Program data goes into a program FIFO one word per register write. Read data comes back through a read FIFO, and each register read of that FIFO removes one word from it.

The array has two partitions. The data partition has two banks of eight pages, and each page holds sixteen words. The info partition has one sixteen-word page per bank. After reset the sequencer sets every array word to all ones before it accepts any command. When a command ends, the block sets a completion flag that software must clear. Command errors set a sticky error bit that software clears with a write of one. A free scratch register is provided for software use.

Top module: `fcmd_seq`

## Requirements
- R1: After reset the status register (offset 3) reads init-busy (bit 1) and busy (bit 2) high while the array is filled with all ones, one word per cycle. Init-busy then falls and the status reads 1 (read-empty, bit 0). Operation status, error and scratch registers read 0 after reset.
- R2: A command starts only on a write to the control register (offset 1) with bit 0 set. Bits [2:1] select the command: 0 read, 1 program, 2 erase. A control write with bit 0 clear starts nothing.
- R3: Control bits [15:8] hold the word count minus one. A value of 0 moves exactly one word and a value of 3 moves four.
- R4: A read pushes words into the read FIFO in ascending address order, starting at the address register (offset 0). The command stalls while the FIFO is full. A read of offset 6 returns the oldest word and removes it. Status bit 0 stays high while the read FIFO is empty.
- R5: Program words are written to offset 6 is not used for this; they go to offset 5, are consumed in order, and each sets the target word to the AND of its old value and the supplied word.
- R6: An erase with control bit 3 clear sets all 16 words of the page that contains the address to ones and leaves the neighbouring pages unchanged.
- R7: An erase with control bit 3 set sets all 128 words of the data bank that contains the address to ones and leaves the other bank unchanged.
- R8: Control bit 4 selects the info partition (word offset modulo 32, one 16-word page per bank). The info partition is separate from the data words at the same offset, and a page erase with bit 4 set clears only the info page.
- R9: Completion sets bit 0 of the operation status register (offset 2). A write with bit 0 clear clears it. A write with bit 0 set leaves it set.
- R10: Errors set bit 0 of the error register (offset 4), which stays set. Writing 1 to bit 0 clears it and writing 0 leaves it set.
- R11: A start while a command or the initial fill is running is ignored and sets the error bit. The running command still delivers correct data.
- R12: A program FIFO write while the FIFO is full is dropped and sets the error bit. Command code 3 sets the error bit and the completion flag and changes no array word.
- R13: The scratch register (offset 7) reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe; pops the read FIFO at offset 6 |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for reg_addr, combinational |

## Verification
Reads are run with lengths of one, four, eight and twenty words. The eight- and twenty-word reads overrun the four-entry read FIFO, so they show whether the sequencer stalls without losing or reordering words. Programs are run over all-ones words and again over already programmed words, which separates an AND update from a plain overwrite. Page and bank erases are placed next to programmed sentinel words in the neighbouring page, the neighbouring bank and the other partition, which shows the extent of each erase. Error cases are a start during the initial fill, a start during a stalled read, a fifth program word into a full FIFO and command code 3.

// File: rtl/fcmd_pkg.sv
// Package: shared register offsets, control/status field positions and
// the command and sequencer state encodings of the flash command sequencer.
package fcmd_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_NONE  = 2'd3
    } fcmd_op_e;

    typedef enum logic [2:0] {
        SQ_INIT,
        SQ_IDLE,
        SQ_READ,
        SQ_PROG,
        SQ_ERASE
    } fcmd_state_e;

    localparam logic [2:0] RA_ADDR    = 3'd0;
    localparam logic [2:0] RA_CTRL    = 3'd1;
    localparam logic [2:0] RA_OPSTAT  = 3'd2;
    localparam logic [2:0] RA_STATUS  = 3'd3;
    localparam logic [2:0] RA_INTR    = 3'd4;
    localparam logic [2:0] RA_PFIFO   = 3'd5;
    localparam logic [2:0] RA_RFIFO   = 3'd6;
    localparam logic [2:0] RA_SCRATCH = 3'd7;

    localparam int CF_START  = 0;
    localparam int CF_OP_LO  = 1;
    localparam int CF_ESEL   = 3;
    localparam int CF_PART   = 4;
    localparam int CF_CNT_LO = 8;

endpackage

// File: rtl/fcmd_fifo.sv
// Synchronous FIFO with first-word fall-through output.
// Assumes: push when full and pop when empty are ignored here; the caller
// detects and reports them. Storage is not reset, only the pointers.
module fcmd_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign rdata   = mem[rd_ptr];

    // Store an accepted word at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Advance pointers and occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
            if (do_pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
            case ({do_push, do_pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/fcmd_array.sv
// Word array standing in for the flash cells: one synchronous write port
// and one combinational read port at the same index.
// Assumes: contents are undefined until the sequencer's initial fill.
module fcmd_array #(
    parameter int W     = 32,
    parameter int WORDS = 288,
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     rdata
);
    logic [W-1:0] cells [WORDS];

    // Write one word per cycle when enabled.
    always_ff @(posedge clk) begin
        if (we) cells[idx] <= wdata;
    end

    assign rdata = cells[idx];
endmodule

// File: rtl/fcmd_ctrl.sv
// Command sequencer: performs the initial all-ones fill, then runs one
// read, program or erase command at a time, one array word per cycle.
// Assumes: page, bank and partition sizes are powers of two; the data
// partition is at least as large as the info partition; the address
// input is a word offset with AW = log2(data words) bits.
module fcmd_ctrl
    import fcmd_pkg::*;
#(
    parameter int W          = 32,
    parameter int CNT_W      = 8,
    parameter int PAGE_WORDS = 16,
    parameter int BANK_WORDS = 128,
    parameter int DATA_WORDS = 256,
    parameter int INFO_WORDS = 32,
    parameter int IDX_W      = 9,
    parameter int AW         = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  fcmd_op_e         op,
    input  logic             bank_sel,
    input  logic             part,
    input  logic [CNT_W-1:0] cnt_m1,
    input  logic [AW-1:0]    addr,
    input  logic             prog_empty,
    input  logic [W-1:0]     prog_data,
    input  logic             rd_full,
    input  logic [W-1:0]     arr_rdata,
    output logic             arr_we,
    output logic [IDX_W-1:0] arr_idx,
    output logic [W-1:0]     arr_wdata,
    output logic             prog_pop,
    output logic             rd_push,
    output logic             busy,
    output logic             init_busy,
    output logic             op_finish,
    output logic             cmd_err
);
    localparam int OFF_W  = AW;
    localparam int IOFF_W = $clog2(INFO_WORDS);
    localparam int TOTAL  = DATA_WORDS + INFO_WORDS;
    localparam int BK_W   = $clog2(BANK_WORDS);
    localparam int REM_W  = (BK_W > CNT_W) ? BK_W : CNT_W;

    fcmd_state_e      state;
    logic [OFF_W-1:0] off_q, off_next, sel_off, start_off;
    logic             part_q, start_part, off_wrap, last, step;
    logic [REM_W-1:0] left_q, start_left;
    logic [IDX_W-1:0] init_q, abs_idx;

    // Map the partition-relative offset onto the flat array index.
    assign abs_idx  = part_q ? (IDX_W'(DATA_WORDS) + IDX_W'(off_q)) : IDX_W'(off_q);
    assign off_wrap = part_q ? (off_q == OFF_W'(INFO_WORDS - 1)) : (off_q == OFF_W'(DATA_WORDS - 1));
    assign off_next = off_wrap ? '0 : off_q + OFF_W'(1);
    assign last     = (left_q == '0);
    assign sel_off  = part ? OFF_W'(addr[IOFF_W-1:0]) : addr;

    // Work out first offset, partition and remaining count of a new command.
    always_comb begin
        start_part = part;
        start_off  = sel_off;
        start_left = REM_W'(cnt_m1);
        if (op == OP_ERASE && bank_sel) begin
            start_part = 1'b0;
            start_off  = addr & ~OFF_W'(BANK_WORDS - 1);
            start_left = REM_W'(BANK_WORDS - 1);
        end else if (op == OP_ERASE) begin
            start_off  = sel_off & ~OFF_W'(PAGE_WORDS - 1);
            start_left = REM_W'(PAGE_WORDS - 1);
        end
    end

    // Drive array, FIFO and completion strobes for the current state.
    always_comb begin
        arr_we    = 1'b0;
        arr_wdata = '1;
        prog_pop  = 1'b0;
        rd_push   = 1'b0;
        step      = 1'b0;
        arr_idx   = abs_idx;
        case (state)
            SQ_INIT: begin
                arr_we  = 1'b1;
                arr_idx = init_q;
            end
            SQ_READ: begin
                rd_push = !rd_full;
                step    = !rd_full;
            end
            SQ_PROG: begin
                prog_pop  = !prog_empty;
                arr_we    = !prog_empty;
                arr_wdata = arr_rdata & prog_data;
                step      = !prog_empty;
            end
            SQ_ERASE: begin
                arr_we = 1'b1;
                step   = 1'b1;
            end
            default: ;
        endcase
    end

    assign busy      = (state != SQ_IDLE);
    assign init_busy = (state == SQ_INIT);
    assign cmd_err   = start && ((state != SQ_IDLE) || (op == OP_NONE));
    assign op_finish = (step && last) || (start && (state == SQ_IDLE) && (op == OP_NONE));

    // Sequencer state, walking offset and remaining word count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SQ_INIT;
            init_q <= '0;
            off_q  <= '0;
            part_q <= 1'b0;
            left_q <= '0;
        end else begin
            case (state)
                SQ_INIT: begin
                    init_q <= init_q + IDX_W'(1);
                    if (init_q == IDX_W'(TOTAL - 1)) state <= SQ_IDLE;
                end
                SQ_IDLE: begin
                    if (start) begin
                        off_q  <= start_off;
                        part_q <= start_part;
                        left_q <= start_left;
                        case (op)
                            OP_READ:  state <= SQ_READ;
                            OP_PROG:  state <= SQ_PROG;
                            OP_ERASE: state <= SQ_ERASE;
                            default:  state <= SQ_IDLE;
                        endcase
                    end
                end
                default: begin
                    if (step) begin
                        off_q  <= off_next;
                        left_q <= left_q - REM_W'(1);
                        if (last) state <= SQ_IDLE;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/fcmd_seq.sv
// Top of the flash command sequencer: register decode and readback,
// completion and error flags, scratch register, and the two FIFOs, the
// word array and the sequencer.
// Assumes: DATA_W >= 16 so the control word fields fit; the register
// port reads combinationally and a read strobe at offset 6 pops one word.
module fcmd_seq
    import fcmd_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int PAGE_WORDS = 16,
    parameter int BANK_PAGES = 8,
    parameter int BANKS      = 2,
    parameter int FIFO_DEPTH = 4,
    parameter int CNT_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);
    localparam int BANK_WORDS = PAGE_WORDS * BANK_PAGES;
    localparam int DATA_WORDS = BANK_WORDS * BANKS;
    localparam int INFO_WORDS = PAGE_WORDS * BANKS;
    localparam int TOTAL      = DATA_WORDS + INFO_WORDS;
    localparam int IDX_W      = $clog2(TOTAL);
    localparam int AW         = $clog2(DATA_WORDS);

    logic [AW-1:0]     addr_q;
    logic [DATA_W-1:0] scratch_q;
    logic              done_q, err_q;
    logic              start_req, pf_req, pf_ovf, rf_pop;
    logic              pf_empty, pf_full, pf_pop, rf_empty, rf_full, rf_push;
    logic [DATA_W-1:0] pf_rdata, rf_rdata, arr_rdata, arr_wdata;
    logic              arr_we, sq_busy, sq_init, op_finish, cmd_err;
    logic [IDX_W-1:0]  arr_idx;

    assign start_req = reg_we && (reg_addr == RA_CTRL) && reg_wdata[CF_START];
    assign pf_req    = reg_we && (reg_addr == RA_PFIFO);
    assign pf_ovf    = pf_req && pf_full;
    assign rf_pop    = reg_re && (reg_addr == RA_RFIFO);

    fcmd_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_prog_fifo (
        .clk(clk), .rst_n(rst_n), .push(pf_req), .wdata(reg_wdata),
        .pop(pf_pop), .rdata(pf_rdata), .empty(pf_empty), .full(pf_full)
    );

    fcmd_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_read_fifo (
        .clk(clk), .rst_n(rst_n), .push(rf_push), .wdata(arr_rdata),
        .pop(rf_pop), .rdata(rf_rdata), .empty(rf_empty), .full(rf_full)
    );

    fcmd_array #(.W(DATA_W), .WORDS(TOTAL), .IDX_W(IDX_W)) u_array (
        .clk(clk), .we(arr_we), .idx(arr_idx), .wdata(arr_wdata), .rdata(arr_rdata)
    );

    fcmd_ctrl #(
        .W(DATA_W), .CNT_W(CNT_W), .PAGE_WORDS(PAGE_WORDS), .BANK_WORDS(BANK_WORDS),
        .DATA_WORDS(DATA_WORDS), .INFO_WORDS(INFO_WORDS), .IDX_W(IDX_W), .AW(AW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start_req),
        .op(fcmd_op_e'(reg_wdata[CF_OP_LO +: 2])),
        .bank_sel(reg_wdata[CF_ESEL]), .part(reg_wdata[CF_PART]),
        .cnt_m1(reg_wdata[CF_CNT_LO +: CNT_W]), .addr(addr_q),
        .prog_empty(pf_empty), .prog_data(pf_rdata), .rd_full(rf_full),
        .arr_rdata(arr_rdata), .arr_we(arr_we), .arr_idx(arr_idx),
        .arr_wdata(arr_wdata), .prog_pop(pf_pop), .rd_push(rf_push),
        .busy(sq_busy), .init_busy(sq_init), .op_finish(op_finish), .cmd_err(cmd_err)
    );

    // Address and scratch registers take plain writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            scratch_q <= '0;
        end else if (reg_we) begin
            if (reg_addr == RA_ADDR)    addr_q    <= reg_wdata[AW-1:0];
            if (reg_addr == RA_SCRATCH) scratch_q <= reg_wdata;
        end
    end

    // Completion flag: set on finish, cleared by a write with bit 0 low.
    always_ff @(posedge clk) begin
        if (!rst_n)                                                  done_q <= 1'b0;
        else if (op_finish)                                          done_q <= 1'b1;
        else if (reg_we && reg_addr == RA_OPSTAT && !reg_wdata[0])   done_q <= 1'b0;
    end

    // Sticky error flag: set on any error, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n)                                                  err_q <= 1'b0;
        else if (cmd_err || pf_ovf)                                  err_q <= 1'b1;
        else if (reg_we && reg_addr == RA_INTR && reg_wdata[0])      err_q <= 1'b0;
    end

    // Register readback multiplexer.
    always_comb begin
        case (reg_addr)
            RA_ADDR:    reg_rdata = DATA_W'(addr_q);
            RA_OPSTAT:  reg_rdata = DATA_W'(done_q);
            RA_STATUS:  reg_rdata = DATA_W'({sq_busy, sq_init, rf_empty});
            RA_INTR:    reg_rdata = DATA_W'(err_q);
            RA_RFIFO:   reg_rdata = rf_rdata;
            RA_SCRATCH: reg_rdata = scratch_q;
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/fcmd_seq_chk.sv
// Checker for the flash command sequencer, bound to the top module.
// Assumes: reset is synchronous and active low; all checks are masked in reset.
module fcmd_seq_chk
    import fcmd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       reg_we,
    input logic [2:0] reg_addr,
    input logic       wdata0,
    input logic       done_q,
    input logic       err_q,
    input logic       sq_busy,
    input logic       pf_full,
    input logic       pf_empty,
    input logic       pf_pop,
    input logic       rf_full,
    input logic       rf_push
);
    // R9: completion flag holds until a clearing write.
    assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_q && !(reg_we && reg_addr == RA_OPSTAT && !wdata0) |=> done_q);

    // R10: error flag holds until a write of one.
    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_q && !(reg_we && reg_addr == RA_INTR && wdata0) |=> err_q);

    // R11: a start while busy raises the error flag.
    assert_busy_start_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we && reg_addr == RA_CTRL && wdata0 && sq_busy |=> err_q);

    // R12: a program FIFO write while full raises the error flag.
    assert_pfifo_ovf_err_R12: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we && reg_addr == RA_PFIFO && pf_full |=> err_q);

    // R4: the sequencer never pushes into a full read FIFO.
    assert_rfifo_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_full |-> !rf_push);

    // R5: program words are only consumed when present.
    assert_pfifo_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pf_pop |-> !pf_empty);
endmodule

bind fcmd_seq fcmd_seq_chk u_fcmd_seq_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .wdata0(reg_wdata[0]), .done_q(done_q), .err_q(err_q), .sq_busy(sq_busy),
    .pf_full(pf_full), .pf_empty(pf_empty), .pf_pop(pf_pop),
    .rf_full(rf_full), .rf_push(rf_push)
);

// File: tb/fcmd_seq_bench.sv
// Scoreboard bench: driver tasks queue expected read words from a model
// of the array; the read monitor pops and compares them as words leave.
module fcmd_seq_bench;
    import fcmd_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_re = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;

    int          checks = 0;
    int          fails = 0;
    logic [31:0] mdl [288];
    logic [31:0] exp_q [$];

    always #4 clk = ~clk;

    fcmd_seq u_fcmd_seq (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(logic [2:0] a, logic pop, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
        reg_re = pop;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    function automatic int midx(int part, int off);
        return part != 0 ? 256 + (off % 32) : (off % 256);
    endfunction

    task automatic issue(int op, int esel, int part, int cnt_m1, int addr);
        reg_wr(RA_ADDR, 32'(addr));
        reg_wr(RA_CTRL, 32'((cnt_m1 << 8) | (part << 4) | (esel << 3) | (op << 1) | 1));
    endtask

    task automatic wait_done(string req);
        logic [31:0] d = 0;
        for (int i = 0; i < 3000; i++) begin
            reg_rd(RA_OPSTAT, 1'b0, d);
            if (d[0]) break;
        end
        chk(req, d & 32'h1, 32'h1);
        reg_wr(RA_OPSTAT, 32'h0);
    endtask

    // Read monitor: pops each word from the read FIFO and scores it.
    task automatic drain(int n, string req);
        logic [31:0] d = 0;
        logic [31:0] e;
        for (int i = 0; i < n; i++) begin
            for (int t = 0; t < 3000; t++) begin
                reg_rd(RA_STATUS, 1'b0, d);
                if (!d[0]) break;
            end
            reg_rd(RA_RFIFO, 1'b1, d);
            e = (exp_q.size() > 0) ? exp_q.pop_front() : 32'hDEAD_BEEF;
            chk(req, d, e);
        end
    endtask

    task automatic do_read(int part, int addr, int n, string req);
        for (int i = 0; i < n; i++) exp_q.push_back(mdl[midx(part, addr + i)]);
        issue(0, 0, part, n - 1, addr);
        drain(n, req);
        wait_done(req);
    endtask

    task automatic do_prog(int part, int addr, int n, logic [31:0] seed);
        logic [31:0] w;
        issue(1, 0, part, n - 1, addr);
        for (int i = 0; i < n; i++) begin
            w = seed ^ (32'h1357_9BDF * 32'(i + 1));
            reg_wr(RA_PFIFO, w);
            mdl[midx(part, addr + i)] = mdl[midx(part, addr + i)] & w;
        end
        wait_done("R5");
    endtask

    task automatic do_erase(int esel, int part, int addr, string req);
        int base;
        issue(2, esel, part, 0, addr);
        if (esel != 0) begin
            base = (addr % 256) & ~127;
            for (int i = 0; i < 128; i++) mdl[base + i] = 32'hFFFF_FFFF;
        end else begin
            base = (part != 0 ? addr % 32 : addr % 256) & ~15;
            for (int i = 0; i < 16; i++) mdl[midx(part, base + i)] = 32'hFFFF_FFFF;
        end
        wait_done(req);
    endtask

    task automatic clear_err();
        reg_wr(RA_INTR, 32'h1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d = 0;
        for (int i = 0; i < 288; i++) mdl[i] = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state while the initial fill runs
        reg_rd(RA_STATUS, 1'b0, d);  chk("R1 status during fill", d, 32'h7);
        reg_rd(RA_OPSTAT, 1'b0, d);  chk("R1 opstat", d, 32'h0);
        reg_rd(RA_INTR, 1'b0, d);    chk("R1 intr", d, 32'h0);
        reg_rd(RA_SCRATCH, 1'b0, d); chk("R1 scratch", d, 32'h0);

        // R11: start during the fill is rejected with an error
        issue(0, 0, 0, 0, 0);
        reg_rd(RA_INTR, 1'b0, d);    chk("R11 start during fill", d, 32'h1);
        for (int i = 0; i < 1000; i++) begin
            reg_rd(RA_STATUS, 1'b0, d);
            if (!d[1]) break;
        end
        chk("R1 status after fill", d, 32'h1);

        // R10: sticky error, cleared only by writing one
        reg_wr(RA_INTR, 32'h0);
        reg_rd(RA_INTR, 1'b0, d);    chk("R10 write zero keeps", d, 32'h1);
        clear_err();
        reg_rd(RA_INTR, 1'b0, d);    chk("R10 write one clears", d, 32'h0);

        // R13: scratch readback
        reg_wr(RA_SCRATCH, 32'hA5A5_1234);
        reg_rd(RA_SCRATCH, 1'b0, d); chk("R13 scratch", d, 32'hA5A5_1234);
        reg_wr(RA_SCRATCH, 32'h0F0F_CAFE);
        reg_rd(RA_SCRATCH, 1'b0, d); chk("R13 scratch", d, 32'h0F0F_CAFE);

        // R2: control write without the start bit does nothing
        reg_wr(RA_ADDR, 32'd5);
        reg_wr(RA_CTRL, 32'h0000_0300);
        repeat (10) @(negedge clk);
        reg_rd(RA_STATUS, 1'b0, d);  chk("R2 no start status", d, 32'h1);
        reg_rd(RA_OPSTAT, 1'b0, d);  chk("R2 no start done", d, 32'h0);

        // R3/R4/R1: four-word read of freshly filled words
        do_read(0, 5, 4, "R3 four words");
        reg_rd(RA_STATUS, 1'b0, d);  chk("R4 empty after drain", d & 32'h1, 32'h1);
        // R3: count field 0 moves one word only
        do_read(0, 200, 1, "R3 single word");
        repeat (4) @(negedge clk);
        reg_rd(RA_STATUS, 1'b0, d);  chk("R3 nothing extra", d, 32'h1);

        // R5: program is an AND with the old contents
        do_prog(0, 16, 3, 32'hF0F0_3C3C);
        do_read(0, 16, 4, "R5 first program");
        do_prog(0, 17, 1, 32'h0FF0_FF00);
        do_read(0, 16, 3, "R5 second program");

        // R9: completion flag clear semantics
        issue(2, 0, 0, 0, 100);
        for (int i = 0; i < 100; i++) begin
            reg_rd(RA_OPSTAT, 1'b0, d);
            if (d[0]) break;
        end
        chk("R9 done set", d, 32'h1);
        reg_wr(RA_OPSTAT, 32'h1);
        reg_rd(RA_OPSTAT, 1'b0, d);  chk("R9 write one keeps", d, 32'h1);
        reg_wr(RA_OPSTAT, 32'h0);
        reg_rd(RA_OPSTAT, 1'b0, d);  chk("R9 write zero clears", d, 32'h0);

        // R6: page erase with sentinels in neighbouring pages
        do_prog(0, 15, 1, 32'h1111_0000);
        do_prog(0, 32, 1, 32'h2222_0000);
        do_prog(0, 20, 2, 32'h3333_0000);
        do_erase(0, 0, 18, "R6");
        do_read(0, 14, 20, "R6 page erase extent");

        // R7: bank erase of bank 1 keeps bank 0
        do_prog(0, 127, 1, 32'h4444_0000);
        do_prog(0, 130, 1, 32'h5555_0000);
        do_prog(0, 255, 1, 32'h6666_0000);
        do_erase(1, 0, 140, "R7");
        do_read(0, 126, 4, "R7 bank boundary");
        do_read(0, 254, 2, "R7 bank end");

        // R8: info partition is separate; info page erase stays there
        do_prog(1, 3, 1, 32'h7777_0000);
        do_prog(1, 20, 1, 32'h8888_0000);
        do_prog(0, 3, 1, 32'h9999_0000);
        do_read(1, 3, 1, "R8 info word");
        do_read(0, 3, 1, "R8 data word");
        do_erase(0, 1, 21, "R8");
        do_read(1, 19, 3, "R8 info page erased");
        do_read(1, 2, 2, "R8 other info page kept");
        do_read(0, 3, 1, "R8 data kept");

        // R11: start during a stalled read is ignored
        do_prog(0, 40, 8, 32'hABCD_1234);
        for (int i = 0; i < 8; i++) exp_q.push_back(mdl[40 + i]);
        issue(0, 0, 0, 7, 40);
        repeat (6) @(negedge clk);
        reg_wr(RA_CTRL, 32'h0000_0003);
        reg_rd(RA_INTR, 1'b0, d);    chk("R11 start while busy", d, 32'h1);
        drain(8, "R11 running read intact");
        wait_done("R11");
        clear_err();
        reg_rd(RA_STATUS, 1'b0, d);  chk("R11 idle after", d, 32'h1);

        // R12: fifth program word into a full FIFO is dropped
        for (int i = 0; i < 5; i++) reg_wr(RA_PFIFO, 32'hC3C3_0000 | 32'(i));
        reg_rd(RA_INTR, 1'b0, d);    chk("R12 overflow error", d, 32'h1);
        clear_err();
        issue(1, 0, 0, 3, 60);
        for (int i = 0; i < 4; i++) mdl[60 + i] = mdl[60 + i] & (32'hC3C3_0000 | 32'(i));
        wait_done("R12");
        do_read(0, 60, 5, "R12 dropped word unused");

        // R12: command code 3 finishes with an error
        issue(3, 0, 0, 0, 60);
        reg_rd(RA_INTR, 1'b0, d);    chk("R12 bad code error", d, 32'h1);
        wait_done("R12 bad code done");
        clear_err();
        do_read(0, 60, 2, "R12 bad code no change");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule